// File: doc/BRIEF.md
# Burst ROM Read Sequencer

This block drives the external bus of one memory area that holds a nibble-mode ROM. A requester hands it a start address through a valid/ready handshake. The block then pulls chip select low and walks the ROM through one access or a burst of back-to-back accesses. Inside a burst, chip select stays low and only the low address bits move. Each word read comes back on a one-cycle valid strobe, and a done strobe marks the last one. The block has no back-pressure on the read-return side: the ROM cannot be stalled, so the consumer must take each `rd_valid` word in the cycle it appears. On the request side, `req_ready` is high only while the block is idle, and a request is taken on any cycle where `req_valid` and `req_ready` are both high.

Three configuration inputs are latched when a request is taken: the ROM data width, a 2-bit burst code and a base wait count. The external active-low `rom_wait_n` input can stretch an access. Whether it is looked at depends on the position of the access in the burst and on two request flags. One flag marks a cache write-back. The other marks a 16-byte DMA move, either to the external area or from an acknowledge-driven device. For either kind of transfer the wait input is not consulted.

Top module: `brc_burst_rom`

## Requirements
- R1: `req_ready` is 1 only while idle. A request is taken when `req_valid && req_ready`. The width, burst, wait and flag inputs are latched at that edge, and later changes to them have no effect on the transfer in flight. `rom_cs_n` goes low in the cycle after acceptance.
- R2: The burst code `cfg_burst` selects the access count: 0 gives one single access, 1 gives 4 accesses, 2 gives 8 and 3 gives 16.
- R3: The width code `cfg_width` selects the ROM width: 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. A 16-bit ROM allows 4 or 8 accesses, and a 32-bit ROM allows only 4. Any combination that is not allowed runs 4 accesses.
- R4: `rom_cs_n` stays low from the first cycle of the first access to the last cycle of the last access, with no high cycle between accesses. It is high in the cycle after the last access.
- R5: The first address is `req_addr` with its bits below the width cleared (width in bytes 1, 2 or 4). Each next address adds the width in bytes and wraps inside the block of (count × width) bytes aligned to that size. `rom_addr` is stable throughout each access.
- R6: The first access lasts 1 + `cfg_wait` cycles when the wait input is not consulted.
- R7: Each later access in a burst lasts max(2, 1 + `cfg_wait`) cycles before any wait extension.
- R8: In the first access, `rom_wait_n` is sampled only if `cfg_wait` ≥ 1. From the nominal last cycle onward, each cycle in which it is sampled low adds one cycle to the access.
- R9: In every later access of a burst, `rom_wait_n` is always sampled, with the same extension rule as R8.
- R10: If `req_cwb` or `req_dma16` was set on the request, `rom_wait_n` is never sampled and no access is extended.
- R11: `rd_valid` pulses for one cycle, in the cycle after each access's last cycle. `rd_data` then holds `rom_data` as sampled in that last cycle, masked to the ROM width: bits [7:0] for width 0, bits [15:0] for width 1, all bits otherwise. The other bits are zero.
- R12: `rd_done` pulses together with the `rd_valid` of the last access only.
- R13: While and after `rst_n` is low: `rom_cs_n` = 1, `req_ready` = 1, and `rd_valid` = `rd_done` = 0, even when reset is applied in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| req_valid | input | 1 | read request present |
| req_ready | output | 1 | block idle, request can be taken |
| req_addr | input | ADDR_W | start byte address |
| req_cwb | input | 1 | request is a cache write-back (wait input not consulted) |
| req_dma16 | input | 1 | request is a 16-byte DMA move (wait input not consulted) |
| cfg_width | input | 2 | ROM width code |
| cfg_burst | input | 2 | burst code, 0 for a single access |
| cfg_wait | input | WAIT_W | base wait cycles per access |
| rom_cs_n | output | 1 | active-low chip select |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_data | input | DATA_W | ROM read data |
| rom_wait_n | input | 1 | active-low wait request from the ROM |
| rd_valid | output | 1 | one-cycle read-data strobe |
| rd_data | output | DATA_W | width-masked read word |
| rd_done | output | 1 | one-cycle end-of-transfer strobe |

## Verification
The bench builds the block with ADDR_W = 16, WAIT_W = 4 and DATA_W = 32. The 16-bit address keeps the wrap blocks and the bench's address-derived ROM pattern easy to predict. The 4-bit wait count lets it program 0, 1, 2 and 3 base waits, so the zero-wait two-cycle floor of later accesses and the stretched cases both come up. With a 32-bit data bus, all three width masks and every legal and illegal width/count pair can be reached.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_ACC  = 1'b1
  } brc_state_e;

  // log2 of the bus width in bytes: 8-bit -> 0, 16-bit -> 1, 32-bit -> 2
  function automatic logic [1:0] step_lg2(input logic [1:0] width_code);
    logic [1:0] r;
    case (width_code)
      2'd0:    r = 2'd0;
      2'd1:    r = 2'd1;
      default: r = 2'd2;
    endcase
    return r;
  endfunction

  // log2 of the access count, with illegal width/length pairs forced to 4
  function automatic logic [2:0] beats_lg2(input logic [1:0] width_code,
                                           input logic [1:0] burst_code);
    logic [2:0] r;
    if (burst_code == 2'd0) begin
      r = 3'd0;
    end else begin
      r = {1'b0, burst_code} + 3'd1;
      if (width_code == 2'd1 && r == 3'd4) r = 3'd2;
      if (width_code[1] && r > 3'd2)        r = 3'd2;
    end
    return r;
  endfunction

endpackage

// File: rtl/brc_cfg_decode.sv
module brc_cfg_decode
  import brc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEAT_W = 5
) (
  input  logic [1:0]        width_code,
  input  logic [1:0]        burst_code,
  output logic [1:0]        step_lg,
  output logic [2:0]        beats_lg,
  output logic              burst_on,
  output logic [BEAT_W-1:0] last_beat,
  output logic [DATA_W-1:0] data_mask
);
  localparam int LOW8  = (DATA_W < 8)  ? DATA_W : 8;
  localparam int LOW16 = (DATA_W < 16) ? DATA_W : 16;

  always_comb begin
    step_lg   = step_lg2(width_code);
    beats_lg  = beats_lg2(width_code, burst_code);
    burst_on  = (burst_code != 2'd0);
    last_beat = (BEAT_W'(1) << beats_lg) - BEAT_W'(1);
    case (step_lg)
      2'd0:    data_mask = DATA_W'({LOW8{1'b1}});
      2'd1:    data_mask = DATA_W'({LOW16{1'b1}});
      default: data_mask = {DATA_W{1'b1}};
    endcase
  end
endmodule

// File: rtl/brc_addr_step.sv
module brc_addr_step #(
  parameter int ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        step_lg,
  input  logic [2:0]        beats_lg,
  output logic [ADDR_W-1:0] next_addr
);
  logic [2:0]        blk_lg;
  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] blk_mask;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    blk_lg     = {1'b0, step_lg} + beats_lg;
    step_bytes = ADDR_W'(1) << step_lg;
    blk_mask   = (ADDR_W'(1) << blk_lg) - ADDR_W'(1);
    sum        = cur_addr + step_bytes;
    next_addr  = (cur_addr & ~blk_mask) | (sum & blk_mask);
  end
endmodule

// File: rtl/brc_access_timer.sv
module brc_access_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              first,
  input  logic              burst_on,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              sample_en,
  input  logic              wait_n,
  output logic              at_nominal,
  output logic              last
);
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] tgt;

  always_comb begin
    tgt = wait_cnt;
    // later burst accesses never shorter than two cycles
    if (!first && burst_on && wait_cnt == '0) tgt = WAIT_W'(1);
    at_nominal = active && (cnt_q >= tgt);
    last       = at_nominal && !(sample_en && !wait_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!active || last)   cnt_q <= '0;
    else if (!at_nominal)       cnt_q <= cnt_q + WAIT_W'(1);
  end
endmodule

// File: rtl/brc_burst_rom.sv
module brc_burst_rom
  import brc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cwb,
  input  logic              req_dma16,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_burst,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              rom_cs_n,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  input  logic              rom_wait_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);
  localparam int BEAT_W = 5;

  brc_state_e        state_q;
  logic [1:0]        width_q;
  logic [1:0]        burst_q;
  logic [WAIT_W-1:0] wait_q;
  logic              ign_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] beat_q;
  logic              vld_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;

  logic [1:0]        step_lg;
  logic [2:0]        beats_lg;
  logic              burst_on;
  logic [BEAT_W-1:0] last_beat;
  logic [DATA_W-1:0] data_mask;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] align_mask;
  logic              accept;
  logic              active;
  logic              first;
  logic              sample_en;
  logic              at_nominal;
  logic              acc_end;
  logic              final_beat;

  brc_cfg_decode #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) dec_i (
    .width_code (width_q),
    .burst_code (burst_q),
    .step_lg    (step_lg),
    .beats_lg   (beats_lg),
    .burst_on   (burst_on),
    .last_beat  (last_beat),
    .data_mask  (data_mask)
  );

  brc_addr_step #(.ADDR_W(ADDR_W)) step_i (
    .cur_addr  (addr_q),
    .step_lg   (step_lg),
    .beats_lg  (beats_lg),
    .next_addr (next_addr)
  );

  brc_access_timer #(.WAIT_W(WAIT_W)) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .first      (first),
    .burst_on   (burst_on),
    .wait_cnt   (wait_q),
    .sample_en  (sample_en),
    .wait_n     (rom_wait_n),
    .at_nominal (at_nominal),
    .last       (acc_end)
  );

  always_comb begin
    active     = (state_q == ST_ACC);
    req_ready  = (state_q == ST_IDLE);
    accept     = req_valid && req_ready;
    first      = (beat_q == '0);
    sample_en  = !ign_q && (!first || wait_q != '0);
    final_beat = (beat_q == last_beat);
    align_mask = (ADDR_W'(1) << step_lg2(cfg_width)) - ADDR_W'(1);
    rom_cs_n   = !active;
    rom_addr   = addr_q;
    rd_valid   = vld_q;
    rd_done    = done_q;
    rd_data    = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      width_q <= '0;
      burst_q <= '0;
      wait_q  <= '0;
      ign_q   <= 1'b0;
      addr_q  <= '0;
      beat_q  <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      vld_q  <= acc_end;
      done_q <= acc_end && final_beat;
      if (accept) begin
        state_q <= ST_ACC;
        width_q <= cfg_width;
        burst_q <= cfg_burst;
        wait_q  <= cfg_wait;
        ign_q   <= req_cwb || req_dma16;
        addr_q  <= req_addr & ~align_mask;
        beat_q  <= '0;
      end else if (acc_end) begin
        data_q <= rom_data & data_mask;
        if (final_beat) begin
          state_q <= ST_IDLE;
        end else begin
          beat_q <= beat_q + BEAT_W'(1);
          addr_q <= next_addr;
        end
      end
    end
  end
endmodule

// File: rtl/brc_burst_rom_chk.sv
module brc_burst_rom_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rom_cs_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rd_valid,
  input logic              rd_done,
  input logic              acc_end,
  input logic              ign,
  input logic              at_nominal
);
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> rom_cs_n);

  a_r4_cs_held_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_done) |-> !rom_cs_n);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && !acc_end) |=> $stable(rom_addr));

  a_r7_no_adjacent_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r10_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (ign && at_nominal) |-> acc_end);

  a_r11_valid_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!rom_cs_n));

  a_r12_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (rd_valid && rom_cs_n));
endmodule

bind brc_burst_rom brc_burst_rom_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rom_cs_n   (rom_cs_n),
  .rom_addr   (rom_addr),
  .rd_valid   (rd_valid),
  .rd_done    (rd_done),
  .acc_end    (acc_end),
  .ign        (ign_q),
  .at_nominal (at_nominal)
);

// File: tb/brc_burst_rom_tb_top.sv
module brc_burst_rom_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WAIT_W = 4;

  typedef struct packed {
    logic [1:0]  w;
    logic [1:0]  b;
    logic [3:0]  wt;
    logic [15:0] a;
    logic        cwb;
    logic        dma;
    logic [7:0]  ws;
    logic [7:0]  we;
  } vec_t;

  // width, burst, wait, addr, cwb, dma16, wait-low window [ws,we)
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd3, 4'd0, 16'h0105, 1'b0, 1'b0, 8'd0, 8'd0},  // R2 16 beats, wrap
    '{2'd1, 2'd2, 4'd1, 16'h020C, 1'b0, 1'b0, 8'd1, 8'd3},  // R8 first stretched
    '{2'd2, 2'd1, 4'd0, 16'h0308, 1'b0, 1'b0, 8'd3, 8'd5},  // R7 R9 later stretched
    '{2'd2, 2'd3, 4'd2, 16'h0404, 1'b0, 1'b0, 8'd0, 8'd0},  // R3 32-bit x16 -> 4
    '{2'd1, 2'd3, 4'd0, 16'h0506, 1'b0, 1'b0, 8'd0, 8'd0},  // R3 16-bit x16 -> 4
    '{2'd0, 2'd0, 4'd3, 16'h0607, 1'b0, 1'b0, 8'd3, 8'd6},  // R2 single, R8
    '{2'd0, 2'd0, 4'd0, 16'h0611, 1'b0, 1'b0, 8'd0, 8'd4},  // R8 wait0 not sampled
    '{2'd2, 2'd1, 4'd0, 16'h0720, 1'b1, 1'b0, 8'd0, 8'd20}, // R10 write-back
    '{2'd0, 2'd1, 4'd0, 16'h00FE, 1'b0, 1'b0, 8'd0, 8'd3},  // R9 R5 wrap
    '{2'd1, 2'd1, 4'd3, 16'h07FF, 1'b0, 1'b0, 8'd2, 8'd2},  // R5 align, R6
    '{2'd3, 2'd2, 4'd2, 16'h0810, 1'b0, 1'b1, 8'd2, 8'd9}   // R10 dma16, R3 code3
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_cwb = 1'b0;
  logic              req_dma16 = 1'b0;
  logic [1:0]        cfg_width = '0;
  logic [1:0]        cfg_burst = '0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic              rom_cs_n;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              rom_wait_n = 1'b1;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              rd_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign rom_data = {rom_addr ^ 16'hA5C3, ~rom_addr};

  brc_burst_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cwb(req_cwb), .req_dma16(req_dma16),
    .cfg_width(cfg_width), .cfg_burst(cfg_burst), .cfg_wait(cfg_wait),
    .rom_cs_n(rom_cs_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .rom_wait_n(rom_wait_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_done(rd_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_beats(input logic [1:0] w, input logic [1:0] b);
    int n;
    case (b)
      2'd0: n = 1;
      2'd1: n = 4;
      2'd2: n = 8;
      default: n = 16;
    endcase
    if (w == 2'd1 && n == 16) n = 4;  // R3
    if (w >= 2'd2 && n > 4) n = 4;    // R3
    return n;
  endfunction

  function automatic logic [31:0] exp_mask(input logic [1:0] w);
    if (w == 2'd0) return 32'h0000_00FF;
    if (w == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    int nb, step, blk, a0, last_e, tt;
    int st [16];
    int en [16];
    int ad [16];
    bit ign;
    nb   = exp_beats(v.w, v.b);
    step = (v.w == 2'd0) ? 1 : (v.w == 2'd1) ? 2 : 4;
    blk  = nb * step;
    a0   = int'(v.a) & ~(step - 1);
    ign  = v.cwb || v.dma;
    tt   = 0;
    for (int i = 0; i < nb; i++) begin
      int len, e;
      bit smp;
      ad[i] = (a0 & ~(blk - 1)) | ((a0 + i * step) & (blk - 1));
      len = (i == 0) ? 1 + int'(v.wt) : ((1 + int'(v.wt) < 2) ? 2 : 1 + int'(v.wt)); // R6 R7
      smp = !ign && (i != 0 || v.wt != 0);
      e = tt + len - 1;
      while (smp && e >= int'(v.ws) && e < int'(v.we)) e++;
      st[i] = tt;
      en[i] = e;
      tt = e + 1;
    end
    last_e = en[nb-1];

    @(negedge clk);
    chk(req_ready == 1'b1, "R1", $sformatf("v%0d ready before", idx), req_ready, 1);
    cfg_width = v.w; cfg_burst = v.b; cfg_wait = v.wt;
    req_addr = v.a; req_cwb = v.cwb; req_dma16 = v.dma;
    req_valid = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= last_e + 1; t++) begin
      int bi, vi;
      string ttag;
      @(negedge clk);
      if (t == 0) begin
        req_valid = 1'b0;
        // R1: scramble config after acceptance
        cfg_width = ~v.w; cfg_burst = ~v.b; cfg_wait = 4'hF;
        req_cwb = ~v.cwb; req_dma16 = 1'b0;
      end
      rom_wait_n = !(t >= int'(v.ws) && t < int'(v.we));
      chk(rom_cs_n == (t > last_e), "R4", $sformatf("v%0d t%0d cs_n", idx, t),
          rom_cs_n, (t > last_e));
      chk(req_ready == (t > last_e), "R1", $sformatf("v%0d t%0d ready", idx, t),
          req_ready, (t > last_e));
      bi = -1; vi = -1;
      for (int i = 0; i < nb; i++) begin
        if (t >= st[i] && t <= en[i]) bi = i;
        if (t == en[i] + 1) vi = i;
      end
      if (bi >= 0)
        chk(rom_addr == ad[bi][15:0], "R5", $sformatf("v%0d beat%0d addr", idx, bi),
            rom_addr, ad[bi]);
      if (vi == 0) ttag = ign ? "R10" : (v.wt != 0 ? "R8" : "R6");
      else         ttag = ign ? "R10" : "R9";
      chk(rd_valid == (vi >= 0), ttag, $sformatf("v%0d t%0d rd_valid", idx, t),
          rd_valid, (vi >= 0));
      if (vi >= 0 && rd_valid) begin
        logic [15:0] ea;
        logic [31:0] ed;
        ea = ad[vi][15:0];
        ed = {ea ^ 16'hA5C3, ~ea} & exp_mask(v.w);
        chk(rd_data == ed, "R11", $sformatf("v%0d beat%0d data", idx, vi), rd_data, ed);
      end
      chk(rd_done == (t == last_e + 1), "R12", $sformatf("v%0d t%0d done", idx, t),
          rd_done, (t == last_e + 1));
    end
    rom_wait_n = 1'b1;
    req_cwb = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    chk(rom_cs_n == 1'b1, "R13", "reset cs_n", rom_cs_n, 1);
    chk(req_ready == 1'b1, "R13", "reset ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R13", "reset rd_valid", rd_valid, 0);
    chk(rd_done == 1'b0, "R13", "reset rd_done", rd_done, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R13: reset in the middle of a burst
    @(negedge clk);
    cfg_width = 2'd0; cfg_burst = 2'd3; cfg_wait = 4'd3; req_addr = 16'h0900;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rom_cs_n == 1'b0, "R1", "burst started", rom_cs_n, 0);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rom_cs_n == 1'b1, "R13", "mid-burst reset cs_n", rom_cs_n, 1);
    chk(req_ready == 1'b1, "R13", "mid-burst reset ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R13", "mid-burst reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rom_cs_n == 1'b1, "R13", "after reset cs_n", rom_cs_n, 1);
    chk(rd_done == 1'b0, "R13", "after reset rd_done", rd_done, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule